// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor with Fault Address Capture

This block watches the bus cycles that the local master starts. While the address strobe is held and neither a data acknowledge nor a bus error has ended the cycle, it counts clock cycles. If the count reaches a programmed limit, the cycle has timed out. On a timeout the block can drive a bus error of its own and can raise a host interrupt. Each of these two actions has its own enable bit. A limit of zero turns the timer off.

Any bus error can end a cycle. It may come from another module on the bus, or it may be the block's own timeout error. In either case the block stores the address of the failing cycle in a register that the host can read, and sets a valid flag. The stored address stays frozen until software clears the flag, so a later error cannot overwrite a fault that has not been read. Capture works the same way in every transfer mode, because the block only sees cycle start, address and cycle end. The timeout error does not depend on whether the board is the system controller.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, `berr_out_o`, `irq_o` and `cap_valid_o` are 0 and `cap_addr_o` is all zeros.
- R2: With `tmo_limit_i` = N > 0 and `berr_en_i` = 1, suppose the strobe is held with no acknowledge and no incoming bus error. Call the first rising edge that samples `as_i` high edge 0. Then `berr_out_o` is low after edges 0 to N-1 and high after edge N.
- R3: An acknowledge (`ack_i` = 1) or an incoming bus error (`berr_in_i` = 1) that is sampled on any edge from 0 to N ends the cycle. No timeout follows, so `berr_out_o` never rises for that cycle.
- R4: With `tmo_limit_i` = 0 the timer is disabled. A strobe held for any length of time gives no local bus error and no interrupt.
- R5: Once high, `berr_out_o` stays high while `as_i` stays high. It goes low after the first edge that samples `as_i` low.
- R6: With `berr_en_i` = 0, a timeout drives no local bus error. Because no bus error occurred, nothing is captured either: `cap_valid_o` stays 0.
- R7: With `irq_en_i` = 1, a timeout sets `irq_o` after edge N. This does not depend on `berr_en_i`. `irq_o` stays set until an edge samples `clear_i` = 1. If a new timeout arrives on that same edge, the set wins. With `irq_en_i` = 0, `irq_o` stays 0.
- R8: When an edge samples `berr_in_i` = 1 with `as_i` = 1 and `cap_valid_o` = 0, the following happens after that edge: `cap_valid_o` = 1, and `cap_addr_o` holds the address that was on `addr_i` at edge 0 of the cycle.
- R9: A local timeout bus error captures the address in the same way. `cap_valid_o` and `berr_out_o` both rise after edge N.
- R10: While `cap_valid_o` = 1 and `clear_i` = 0, further bus errors leave `cap_addr_o` unchanged. An edge that samples `clear_i` = 1 clears `cap_valid_o`. If a bus error is sampled on that same edge, the new address is captured and `cap_valid_o` stays 1.
- R11: Changes on `addr_i` after edge 0 of a cycle have no effect on the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe of a local master cycle, active high |
| addr_i | input | ADDR_W | Bus address of the current cycle |
| ack_i | input | 1 | Data acknowledge, ends the cycle |
| berr_in_i | input | 1 | Bus error seen on the bus from any source |
| tmo_limit_i | input | CNT_W | Timeout length in clock cycles, 0 disables the timer |
| berr_en_i | input | 1 | Enables the local bus error on timeout |
| irq_en_i | input | 1 | Enables the host interrupt on timeout |
| clear_i | input | 1 | Software clear of the capture valid flag and the interrupt |
| berr_out_o | output | 1 | Locally generated bus error |
| irq_o | output | 1 | Host interrupt, set on timeout |
| cap_valid_o | output | 1 | Captured address is valid |
| cap_addr_o | output | ADDR_W | Address of the cycle that ended in bus error |

## Verification
The hardest case is an acknowledge that arrives in the very cycle in which the timer would expire. That is edge N, one edge away from edge N-1, where the acknowledge only clears the counter. To reach it, the bench sweeps every limit from 1 to 6 against every acknowledge edge from 0 to N. Another hard case is a software clear on the same edge as a fresh bus error. The bench lines these up exactly, on the edge after a capture that is already frozen. It also moves `addr_i` partway through each cycle, which shows that only the address present at the start of the cycle is kept.

// File: rtl/bto_pkg.sv
package bto_pkg;
  // True when a running count has reached a nonzero limit.
  function automatic logic limit_reached(logic [31:0] cnt, logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim);
  endfunction

  // Next count value: saturate at the limit.
  function automatic logic [31:0] count_step(logic [31:0] cnt, logic [31:0] lim);
    return (cnt < lim) ? cnt + 32'd1 : cnt;
  endfunction
endpackage

// File: rtl/bto_timer.sv
module bto_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] count_q;
  logic             fired_q;
  logic [31:0]      step;

  always_comb begin
    step      = bto_pkg::count_step(32'(count_q), 32'(limit_i));
    timeout_o = as_i && !end_i && !fired_q &&
                bto_pkg::limit_reached(32'(count_q), 32'(limit_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fired_q <= 1'b0;
    end else if (!as_i || end_i) begin
      count_q <= '0;
      fired_q <= 1'b0;
    end else begin
      count_q <= step[CNT_W-1:0];
      if (timeout_o) fired_q <= 1'b1;
    end
  end

  // R4: a disabled timer never expires
  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |-> !timeout_o);

  // R3: a cycle that has just ended starts again from zero
  a_r3_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> (count_q == '0));
endmodule

// File: rtl/bto_local_err.sv
module bto_local_err (
  input  logic clk,
  input  logic rst_n,
  input  logic as_i,
  input  logic timeout_i,
  input  logic berr_en_i,
  input  logic irq_en_i,
  input  logic clear_i,
  output logic berr_o,
  output logic irq_o
);
  logic berr_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!as_i)                       berr_q <= 1'b0;
      else if (timeout_i && berr_en_i) berr_q <= 1'b1;
      if (timeout_i && irq_en_i)       irq_q  <= 1'b1;
      else if (clear_i)                irq_q  <= 1'b0;
    end
  end

  assign berr_o = berr_q;
  assign irq_o  = irq_q;

  // R5: the local error holds while the strobe stays asserted
  a_r5_berr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_o && as_i) |=> berr_o);

  // R5: the local error is never present with the strobe released
  a_r5_berr_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> $past(as_i));

  // R7: the interrupt is sticky until software clears it
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clear_i) |=> irq_o);
endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              err_evt_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              as_q;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic [ADDR_W-1:0] cyc_addr;
  logic              cycle_start;
  logic              valid_after_clear;
  logic              take;

  always_comb begin
    cycle_start       = as_i && !as_q;
    cyc_addr          = cycle_start ? addr_i : cyc_addr_q;
    valid_after_clear = valid_o && !clear_i;
    take              = err_evt_i && !valid_after_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q       <= 1'b0;
      cyc_addr_q <= '0;
      valid_o    <= 1'b0;
      addr_o     <= '0;
    end else begin
      as_q <= as_i;
      if (cycle_start) cyc_addr_q <= addr_i;
      if (take) begin
        valid_o <= 1'b1;
        addr_o  <= cyc_addr;
      end else begin
        valid_o <= valid_after_clear;
      end
    end
  end

  // R10: a valid capture is frozen until cleared
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !clear_i) |=> (valid_o && $stable(addr_o)));

  // R8: a capture only happens on an error event
  a_r8_set_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(err_evt_i));
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  input  logic              berr_in_i,
  input  logic [CNT_W-1:0]  tmo_limit_i,
  input  logic              berr_en_i,
  input  logic              irq_en_i,
  input  logic              clear_i,
  output logic              berr_out_o,
  output logic              irq_o,
  output logic              cap_valid_o,
  output logic [ADDR_W-1:0] cap_addr_o
);
  logic cycle_end;
  logic timeout_evt;
  logic err_evt;

  assign cycle_end = ack_i || berr_in_i;
  assign err_evt   = as_i && (berr_in_i || (timeout_evt && berr_en_i));

  bto_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .end_i(cycle_end),
    .limit_i(tmo_limit_i), .timeout_o(timeout_evt)
  );

  bto_local_err u_err (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .timeout_i(timeout_evt),
    .berr_en_i(berr_en_i), .irq_en_i(irq_en_i), .clear_i(clear_i),
    .berr_o(berr_out_o), .irq_o(irq_o)
  );

  bto_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .addr_i(addr_i),
    .err_evt_i(err_evt), .clear_i(clear_i),
    .valid_o(cap_valid_o), .addr_o(cap_addr_o)
  );

  // R2: a local error rises only from an enabled, nonzero timer
  a_r2_rise_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_out_o) |-> ($past(tmo_limit_i) != '0 && $past(berr_en_i)));

  // R9: a local error that rises while nothing is held gets captured
  a_r9_local_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(berr_out_o) && !$past(cap_valid_o)) |-> cap_valid_o);

  // R6: a timeout with the error disabled drives no bus error
  a_r6_no_berr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && !berr_en_i && !berr_out_o) |=> !berr_out_o);
endmodule

// File: tb/bus_timeout_monitor_test.sv
module bus_timeout_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          as_i = 1'b0, ack_i = 1'b0, berr_in_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] tmo_limit_i = '0;
  logic          berr_en_i = 1'b0, irq_en_i = 1'b0, clear_i = 1'b0;
  logic          berr_out_o, irq_o, cap_valid_o;
  logic [AW-1:0] cap_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_timeout_monitor #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .addr_i(addr_i), .ack_i(ack_i),
    .berr_in_i(berr_in_i), .tmo_limit_i(tmo_limit_i), .berr_en_i(berr_en_i),
    .irq_en_i(irq_en_i), .clear_i(clear_i), .berr_out_o(berr_out_o),
    .irq_o(irq_o), .cap_valid_o(cap_valid_o), .cap_addr_o(cap_addr_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_clear();
    clear_i = 1'b1; tick(); clear_i = 1'b0;
  endtask

  // Timeout sweep: edge k is the k-th edge sampling the strobe high.
  task automatic run_timeout(input int n, input bit ben, input bit ien, input logic [AW-1:0] a);
    bit eb;
    tmo_limit_i = CW'(n); berr_en_i = ben; irq_en_i = ien;
    as_i = 1'b1; addr_i = a;
    for (int k = 0; k <= n + 2; k++) begin
      tick();
      if (k == 0) addr_i = ~a;  // R11: address moves after edge 0
      eb = ben && (k >= n);
      check(berr_out_o == eb, "R2 berr_out", berr_out_o, eb);
      check(irq_o == (ien && k >= n), "R7 irq", irq_o, ien && k >= n);
      check(cap_valid_o == eb, ben ? "R9 cap_valid" : "R6 cap_valid", cap_valid_o, eb);
    end
    if (ben) check(cap_addr_o == a, "R11 cap_addr", cap_addr_o, a);
    as_i = 1'b0; tick();
    check(berr_out_o == 1'b0, "R5 berr released", berr_out_o, 0);
    check(irq_o == ien, "R7 irq held", irq_o, ien);
    do_clear();
    check(irq_o == 1'b0, "R7 irq cleared", irq_o, 0);
    check(cap_valid_o == 1'b0, "R10 valid cleared", cap_valid_o, 0);
  endtask

  // Acknowledge or incoming error sampled on edge j (0..n) prevents a timeout.
  task automatic run_end(input int n, input int j, input bit use_berr);
    tmo_limit_i = CW'(n); berr_en_i = 1'b1; irq_en_i = 1'b1;
    as_i = 1'b1; addr_i = AW'(32'h1000 + j);
    for (int k = 0; k <= n + 2; k++) begin
      if (k == j) begin
        if (use_berr) berr_in_i = 1'b1; else ack_i = 1'b1;
      end
      tick();
      if (k == j) begin ack_i = 1'b0; berr_in_i = 1'b0; as_i = 1'b0; end
      check(berr_out_o == 1'b0, "R3 no timeout after end", berr_out_o, 0);
      check(irq_o == 1'b0, "R3 no irq after end", irq_o, 0);
    end
    check(cap_valid_o == use_berr, "R8 capture on incoming error", cap_valid_o, use_berr);
    if (use_berr)
      check(cap_addr_o == AW'(32'h1000 + j), "R8 cap_addr", cap_addr_o, 32'h1000 + j);
    do_clear();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(berr_out_o == 0 && irq_o == 0 && cap_valid_o == 0, "R1 reset flags", {berr_out_o, irq_o, cap_valid_o}, 0);
    check(cap_addr_o == '0, "R1 reset addr", cap_addr_o, 0);
    rst_n = 1'b1; tick();

    for (int n = 1; n <= 6; n++)
      for (int m = 0; m < 4; m++)
        run_timeout(n, m[0], m[1], AW'(32'hA000_0000 + n * 16 + m));

    for (int n = 1; n <= 6; n++)
      for (int j = 0; j <= n; j++) begin
        run_end(n, j, 1'b0);
        run_end(n, j, 1'b1);
      end

    // R4 limit zero disables
    tmo_limit_i = '0; berr_en_i = 1'b1; irq_en_i = 1'b1; as_i = 1'b1;
    for (int k = 0; k < 300; k++) tick();
    check(berr_out_o == 0 && irq_o == 0 && cap_valid_o == 0, "R4 disabled timer", {berr_out_o, irq_o, cap_valid_o}, 0);
    as_i = 1'b0; tick();

    // R10 frozen capture, then clear coincident with a new error
    tmo_limit_i = CW'(50);
    as_i = 1'b1; addr_i = 32'h1111_0000; tick(); berr_in_i = 1'b1; tick();
    berr_in_i = 1'b0; as_i = 1'b0; tick();
    check(cap_valid_o && cap_addr_o == 32'h1111_0000, "R8 first capture", cap_addr_o, 32'h1111_0000);
    as_i = 1'b1; addr_i = 32'h2222_0000; tick(); berr_in_i = 1'b1; tick();
    berr_in_i = 1'b0; as_i = 1'b0; tick();
    check(cap_addr_o == 32'h1111_0000, "R10 frozen addr", cap_addr_o, 32'h1111_0000);
    check(cap_valid_o == 1'b1, "R10 still valid", cap_valid_o, 1);
    as_i = 1'b1; addr_i = 32'h3333_0000; tick(); berr_in_i = 1'b1; clear_i = 1'b1; tick();
    berr_in_i = 1'b0; clear_i = 1'b0; as_i = 1'b0; tick();
    check(cap_valid_o && cap_addr_o == 32'h3333_0000, "R10 clear with new error", cap_addr_o, 32'h3333_0000);
    do_clear();
    check(cap_valid_o == 1'b0, "R10 cleared", cap_valid_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule